// File: doc/BRIEF.md
# Descriptor-Chaining DMA Channel

This block is one DMA channel that copies data between two memory-mapped regions through a request/grant/response memory port. Software reaches it through a small register port. The registers are a control word, a status word, source, destination, byte count and a current-descriptor pointer. Software writes the registers and then makes a 0-to-1 transition on the start bit. The channel then runs until it completes or fails.

The channel has two modes. In direct mode, the source, destination and count come from the registers. Either the source address or the destination address can be held fixed, with its own access width. In chaining mode, the channel reads a four-word descriptor from memory and moves that segment. It then follows the next-descriptor link on its own until a descriptor marked as the last one is done. This lets a contiguous buffer be scattered to several destinations, or several sources be gathered into one buffer. The hold enables are ignored while chaining.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, the status word reads 0, the control word reads 0 and `mem_req` stays low while the channel is not busy.
- R2: A direct transfer repeats read-then-write beats. Each beat reads 4 bytes at the source (size code 2) and writes that data to the destination. Both addresses advance by 4 and the count drops by 4, until the count reaches 0.
- R3: In direct mode, control bit 3 holds the destination address fixed. Bits 7:6 then give the access size of every beat on both sides (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The source advances and the count drops by that many bytes per beat.
- R4: In direct mode, control bit 2 holds the source address fixed. Bits 5:4 give the size of every beat, and the destination advances by that many bytes per beat.
- R5: Starting a direct transfer with both bit 2 and bit 3 set raises status bit 3 (configuration error) and makes no memory access. Busy stays low.
- R6: A transfer starts only on a write that changes control bit 0 from 0 to 1. Writing 1 when the bit is already 1 does nothing. Writes to control, address and count registers are ignored while busy.
- R7: With control bit 1 set, a start reads four words at the descriptor pointer, at offsets 0, 4, 8 and 12. In that order they are: source, destination, next-descriptor address (bit 0 = last flag, bits 3:0 dropped), byte count. The channel then moves that segment in 4-byte beats.
- R8: After a segment, the next descriptor is fetched with no software action unless the last flag was set. A descriptor with count 0 makes no data access.
- R9: In chaining mode the hold enables have no effect: both addresses advance and beats are 4 bytes.
- R10: An error response on any access sets status bit 2, clears busy and stops the channel. The descriptor pointer keeps the failing descriptor's address, and source/destination keep the failing beat's addresses.
- R11: Normal completion sets status bit 1 and pulses `done` for exactly one cycle, in the cycle busy falls.
- R12: Writing 1 to status bits 1, 2 or 3 clears those bits.
- R13: A request stays asserted with a stable address until granted, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 ctrl, 1 status, 2 src, 3 dst, 4 count, 5 descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rsp | input | 1 | Response for the accepted access |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data, valid with `mem_rsp` |
| done | output | 1 | One-cycle pulse on normal completion |

## Verification
The bench grants each request in the same cycle it appears and returns the response one cycle later. The next request is visible in the cycle after the response is taken, so every access can be compared in the falling-edge half-cycle where it is first driven. A scoreboard queue holds the exact order of expected accesses (descriptor fetches, reads, writes), each with its expected write data. Status, address registers and the done count are read only after busy is seen low, since busy falls and `done` pulses in the cycle after the final response.

// File: rtl/dma_chain_channel.sv
module dma_chain_channel #(
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rsp,
  input  logic        mem_rsp_err,
  input  logic [31:0] mem_rdata,
  output logic        done
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2,
                         A_DST = 3'd3, A_CNT = 3'd4, A_DESC = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_SEG} state_t;

  state_t           state;
  logic [7:0]       ctrl_q;
  logic [31:0]      src_q, dst_q, desc_q, next_q, data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q, wait_q;
  logic [1:0]       widx;
  logic             busy_q, eot_q, err_q, cfg_q, done_q;

  wire chain_m = ctrl_q[1];
  wire s_hold  = !chain_m && ctrl_q[2];
  wire d_hold  = !chain_m && ctrl_q[3];
  wire [1:0] raw_sz  = s_hold ? ctrl_q[5:4] : d_hold ? ctrl_q[7:6] : 2'd2;
  wire [1:0] beat_sz = (raw_sz == 2'd3) ? 2'd2 : raw_sz;
  wire [2:0] bytes   = 3'd1 << beat_sz;
  wire [CNT_W-1:0] bytes_c = {{(CNT_W-3){1'b0}}, bytes};

  wire wr_ok      = reg_wr && !busy_q;
  wire start_edge = wr_ok && reg_addr == A_CTRL && reg_wdata[0] && !ctrl_q[0];
  wire bad_hold   = !reg_wdata[1] && reg_wdata[2] && reg_wdata[3];
  wire rsp_ok     = wait_q && mem_rsp && !mem_rsp_err;

  assign mem_req   = (state == S_FETCH || state == S_RD || state == S_WR) && !wait_q;
  assign mem_we    = state == S_WR;
  assign mem_addr  = (state == S_FETCH) ? desc_q + {28'd0, widx, 2'b00}
                   : (state == S_RD) ? src_q : dst_q;
  assign mem_size  = (state == S_FETCH) ? 2'd2 : beat_sz;
  assign mem_wdata = data_q;
  assign done      = done_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {24'd0, ctrl_q};
      A_STAT:  reg_rdata = {28'd0, cfg_q, err_q, eot_q, busy_q};
      A_SRC:   reg_rdata = src_q;
      A_DST:   reg_rdata = dst_q;
      A_CNT:   reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      A_DESC:  reg_rdata = desc_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      desc_q <= '0;
      next_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
      wait_q <= 1'b0;
      widx   <= '0;
      busy_q <= 1'b0;
      eot_q  <= 1'b0;
      err_q  <= 1'b0;
      cfg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;

      if (reg_wr && reg_addr == A_STAT) begin
        if (reg_wdata[1]) eot_q <= 1'b0;
        if (reg_wdata[2]) err_q <= 1'b0;
        if (reg_wdata[3]) cfg_q <= 1'b0;
      end

      if (wr_ok) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= reg_wdata[7:0];
          A_SRC:  src_q  <= reg_wdata;
          A_DST:  dst_q  <= reg_wdata;
          A_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
          A_DESC: desc_q <= reg_wdata;
          default: ;
        endcase
      end

      if (start_edge) begin
        if (bad_hold) begin
          cfg_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          widx   <= '0;
          if (reg_wdata[1]) begin
            state <= S_FETCH;
          end else begin
            last_q <= 1'b1;
            state  <= (cnt_q == '0) ? S_SEG : S_RD;
          end
        end
      end

      if (mem_req && mem_gnt) wait_q <= 1'b1;

      if (wait_q && mem_rsp) begin
        wait_q <= 1'b0;
        if (mem_rsp_err) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
      end

      if (rsp_ok) begin
        case (state)
          S_FETCH: begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: src_q <= mem_rdata;
              2'd1: dst_q <= mem_rdata;
              2'd2: begin
                next_q <= {mem_rdata[31:4], 4'b0000};
                last_q <= mem_rdata[0];
              end
              default: begin
                cnt_q <= mem_rdata[CNT_W-1:0];
                state <= (mem_rdata[CNT_W-1:0] == '0) ? S_SEG : S_RD;
              end
            endcase
          end
          S_RD: begin
            data_q <= mem_rdata;
            state  <= S_WR;
          end
          S_WR: begin
            if (!s_hold) src_q <= src_q + {29'd0, bytes};
            if (!d_hold) dst_q <= dst_q + {29'd0, bytes};
            if (cnt_q <= bytes_c) begin
              cnt_q <= '0;
              state <= S_SEG;
            end else begin
              cnt_q <= cnt_q - bytes_c;
              state <= S_RD;
            end
          end
          default: ;
        endcase
      end

      if (state == S_SEG) begin
        if (chain_m && !last_q) begin
          desc_q <= next_q;
          widx   <= '0;
          state  <= S_FETCH;
        end else begin
          busy_q <= 1'b0;
          eot_q  <= 1'b1;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
      end
    end
  end
endmodule

module dma_chain_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic        done,
  input logic        busy_q,
  input logic        err_q,
  input logic        cfg_q,
  input logic [7:0]  ctrl_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mem_req);

  assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(ctrl_q));

  assert_cfg_nostart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q) |-> !busy_q);

  assert_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy_q);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q && $past(busy_q));

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
endmodule

bind dma_chain_channel dma_chain_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .done(done), .busy_q(busy_q), .err_q(err_q),
  .cfg_q(cfg_q), .ctrl_q(ctrl_q)
);

// File: tb/dma_chain_channel_test.sv
module dma_chain_channel_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, done;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_rsp = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rsp(mem_rsp),
    .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata), .done(done)
  );

  assign mem_gnt = mem_req;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] data;
    string       tag;
  } acc_t;

  acc_t        exp_q[$];
  logic [31:0] dmem [logic [31:0]];
  int          checks = 0, fails = 0, done_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        pend = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : (a ^ 32'hC3C3_0000);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input string tag, input logic [31:0] a, input logic [1:0] sz);
    acc_t e;
    e.we = 1'b0; e.addr = a; e.sz = sz; e.data = '0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_wr(input string tag, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    acc_t e;
    e.we = 1'b1; e.addr = a; e.sz = sz; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_fetch(input string tag, input logic [31:0] base);
    for (int i = 0; i < 4; i++) exp_rd(tag, base + 32'(4*i), 2'd2);
  endtask

  always @(negedge clk) begin
    if (done) done_cnt++;
    mem_rsp     <= pend;
    mem_rsp_err <= pend && pend_err;
    mem_rdata   <= pend ? rd(pend_addr) : 32'd0;
    pend        <= 1'b0;
    if (mem_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected access actual=%h we=%0d expected=none", mem_addr, mem_we);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr || mem_size !== e.sz ||
            (e.we && mem_wdata !== e.data)) begin
          fails++;
          $display("FAIL %s access actual=%0d/%h/%0d/%h expected=%0d/%h/%0d/%h",
                   e.tag, mem_we, mem_addr, mem_size, mem_wdata,
                   e.we, e.addr, e.sz, e.data);
        end
      end
      pend      <= 1'b1;
      pend_addr <= mem_addr;
      pend_err  <= (mem_addr == err_addr);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic start(input logic [7:0] c);
    wr(3'd0, {24'd0, c & 8'hFE});
    wr(3'd0, {24'd0, c | 8'h01});
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rdreg(3'd1, s);
      if (!s[0]) break;
    end
    repeat (3) @(negedge clk);
    chk({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic stat(input string tag, input logic [31:0] exp);
    logic [31:0] s;
    rdreg(3'd1, s);
    chk(tag, s, exp);
  endtask

  task automatic regchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] s;
    rdreg(a, s);
    chk(tag, s, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    rdreg(3'd1, reg_rdata);
    stat("R1 status after reset", 32'd0);
    regchk("R1 ctrl after reset", 3'd0, 32'd0);
    chk("R1 no request in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no request idle", {31'd0, mem_req}, 32'd0);

    // R2 direct word transfer
    dc = done_cnt;
    wr(3'd2, 32'h1000); wr(3'd3, 32'h2000); wr(3'd4, 32'd12);
    for (int i = 0; i < 3; i++) begin
      exp_rd("R2 read", 32'h1000 + 32'(4*i), 2'd2);
      exp_wr("R2 write", 32'h2000 + 32'(4*i), 2'd2, rd(32'h1000 + 32'(4*i)));
    end
    start(8'h00);
    wait_idle("R2");
    stat("R11 end status direct", 32'h2);
    chk("R11 one done pulse", 32'(done_cnt - dc), 32'd1);
    regchk("R2 src advanced", 3'd2, 32'h100C);
    regchk("R2 count zero", 3'd4, 32'd0);
    wr(3'd1, 32'h2);
    stat("R12 end bit cleared", 32'd0);

    // R6 no start without a 0->1 edge (ctrl bit0 already 1)
    wr(3'd4, 32'd4);
    wr(3'd0, 32'h1);
    repeat (5) @(negedge clk);
    stat("R6 no start on repeated 1", 32'd0);
    chk("R6 no access", 32'(exp_q.size()), 32'd0);

    // R3 destination hold, 2-byte beats
    wr(3'd2, 32'h1000); wr(3'd3, 32'h3000); wr(3'd4, 32'd6);
    for (int i = 0; i < 3; i++) begin
      exp_rd("R3 read", 32'h1000 + 32'(2*i), 2'd1);
      exp_wr("R3 write held", 32'h3000, 2'd1, rd(32'h1000 + 32'(2*i)));
    end
    start(8'h48);
    wait_idle("R3");
    regchk("R3 dst unchanged", 3'd3, 32'h3000);
    regchk("R3 src advanced", 3'd2, 32'h1006);
    wr(3'd1, 32'h2);

    // R4 source hold, 1-byte beats
    wr(3'd2, 32'h4000); wr(3'd3, 32'h5000); wr(3'd4, 32'd3);
    for (int i = 0; i < 3; i++) begin
      exp_rd("R4 read held", 32'h4000, 2'd0);
      exp_wr("R4 write", 32'h5000 + 32'(i), 2'd0, rd(32'h4000));
    end
    start(8'h04);
    wait_idle("R4");
    regchk("R4 src unchanged", 3'd2, 32'h4000);
    regchk("R4 dst advanced", 3'd3, 32'h5003);
    wr(3'd1, 32'h2);

    // R5 both holds rejected
    dc = done_cnt;
    wr(3'd4, 32'd8);
    start(8'h0C);
    repeat (6) @(negedge clk);
    stat("R5 config error, not busy", 32'h8);
    chk("R5 no done", 32'(done_cnt - dc), 32'd0);
    wr(3'd1, 32'h8);
    stat("R12 config bit cleared", 32'd0);

    // R7 R8 R9 chain of two, holds set but ignored
    dmem[32'h100] = 32'h6000; dmem[32'h104] = 32'h7000;
    dmem[32'h108] = 32'h200;  dmem[32'h10C] = 32'd8;
    dmem[32'h200] = 32'h6100; dmem[32'h204] = 32'h7100;
    dmem[32'h208] = 32'h301;  dmem[32'h20C] = 32'd4;
    dc = done_cnt;
    wr(3'd5, 32'h100);
    exp_fetch("R7 fetch first", 32'h100);
    for (int i = 0; i < 2; i++) begin
      exp_rd("R9 chain read", 32'h6000 + 32'(4*i), 2'd2);
      exp_wr("R9 chain write", 32'h7000 + 32'(4*i), 2'd2, rd(32'h6000 + 32'(4*i)));
    end
    exp_fetch("R8 fetch next", 32'h200);
    exp_rd("R7 seg2 read", 32'h6100, 2'd2);
    exp_wr("R7 seg2 write", 32'h7100, 2'd2, rd(32'h6100));
    start(8'h0E);
    wait_idle("R8");
    stat("R11 end status chain", 32'h2);
    chk("R11 chain single done", 32'(done_cnt - dc), 32'd1);
    regchk("R8 pointer at last", 3'd5, 32'h200);
    wr(3'd1, 32'h2);

    // R8 zero-count segment, R10 error in descriptor fetch
    dmem[32'h400] = 32'h8000; dmem[32'h404] = 32'h9000;
    dmem[32'h408] = 32'h500;  dmem[32'h40C] = 32'd0;
    dmem[32'h500] = 32'h8100; dmem[32'h504] = 32'h9100;
    dmem[32'h508] = 32'h600;  dmem[32'h50C] = 32'd4;
    dc = done_cnt;
    err_addr = 32'h608;
    wr(3'd5, 32'h400);
    exp_fetch("R8 zero seg fetch", 32'h400);
    exp_fetch("R8 after zero seg", 32'h500);
    exp_rd("R8 read", 32'h8100, 2'd2);
    exp_wr("R8 write", 32'h9100, 2'd2, rd(32'h8100));
    exp_rd("R10 fetch", 32'h600, 2'd2);
    exp_rd("R10 fetch", 32'h604, 2'd2);
    exp_rd("R10 fetch err", 32'h608, 2'd2);
    start(8'h02);
    wait_idle("R10 fetch");
    stat("R10 error status", 32'h4);
    regchk("R10 pointer kept", 3'd5, 32'h600);
    chk("R10 no done on error", 32'(done_cnt - dc), 32'd0);
    wr(3'd1, 32'h4);
    stat("R12 error bit cleared", 32'd0);

    // R10 error on a data write in direct mode
    err_addr = 32'hB004;
    wr(3'd2, 32'hA000); wr(3'd3, 32'hB000); wr(3'd4, 32'd8);
    exp_rd("R10 direct read", 32'hA000, 2'd2);
    exp_wr("R10 direct write", 32'hB000, 2'd2, rd(32'hA000));
    exp_rd("R10 direct read", 32'hA004, 2'd2);
    exp_wr("R10 direct write err", 32'hB004, 2'd2, rd(32'hA004));
    start(8'h00);
    wait_idle("R10 data");
    stat("R10 data error status", 32'h4);
    regchk("R10 src at failing beat", 3'd2, 32'hA004);
    regchk("R10 count left", 3'd4, 32'd4);
    err_addr = 32'hFFFF_FFFF;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule